// File: doc/BRIEF.md
# Synchronous Packet FIFO with Repeat Readout

This block is a single-clock first-in first-out buffer. Both of its sides use a valid/ready handshake. A word moves when valid and ready are both high at a rising clock edge. The block reports how many words it holds and raises a flag once that count reaches a threshold set at build time.

Several behaviours can be switched on separately when the block is built:

- An end-of-packet bit can be stored with each word.
- In packet mode, nothing is offered on the read side until a whole packet has arrived.
- An abort input throws away a packet that is still being written.
- In repeat-readout mode, a stored packet can be read any number of times before it is released.
- A pipeline register can be placed after the storage read port. This register cannot be combined with repeat-readout mode.

Storage is a plain array with one write port and one read port.

The buffer is meant for packets that must reach a consumer whole: a receiver may still reject a frame after part of it has been written, or a transmitter may have to replay a frame.

Top module: `pkt_fifo`

## Requirements
- R1: After a synchronous reset, `rd_valid` is 0, `fill` is 0, `wr_ready` is 1 and `near_full` is 0, whatever was held before the reset.
- R2: Words leave in the order in which they were accepted. When `KEEP_LAST` is 1, `rd_last` carries the `wr_last` bit that was written with that word. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value.
- R3: `wr_ready` is 0 while `fill` equals `DEPTH`. A write presented at that time is not accepted and does not change `fill`.
- R4: `fill` counts the words held: accepted writes minus released reads, minus any words thrown away by an abort.
- R5: `near_full` is 1 exactly when `fill` is greater than or equal to `NEAR_LEVEL`.
- R6: With `PKT_MODE` set, `rd_valid` stays 0 until a write with `wr_last` = 1 has been accepted. Words of a packet that is still being written are never offered.
- R7: With `ABORT_EN` set, a cycle with `wr_abort` = 1 removes every word accepted since the last accepted write with `wr_last` = 1. A write beat presented in the same cycle as the abort is also thrown away.
- R8: An abort while no packet is partly written changes neither `fill` nor `rd_valid`.
- R9: With `REPEAT_EN` set, a read handshake taken while `rd_keep` = 1 does not reduce `fill`. The handshake of the word with `rd_last` = 1 brings the read position back to the first word of that packet.
- R10: A readout of a packet with `rd_keep` = 0 releases each word as it is read. The packet can then no longer be read.
- R11: With `OUT_PIPE` set and `PKT_MODE` clear, a word written into an empty buffer appears on `rd_valid`/`rd_data` two clock edges after its write. `fill` includes the word held in the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Buffer can take a write beat |
| wr_data | input | DATA_W | Write word |
| wr_last | input | 1 | Write beat ends a packet |
| wr_abort | input | 1 | Throw away the packet now being written |
| rd_valid | output | 1 | Read word offered |
| rd_ready | input | 1 | Consumer takes the offered word |
| rd_data | output | DATA_W | Read word |
| rd_last | output | 1 | Read word ends a packet (0 when `KEEP_LAST` is 0) |
| rd_keep | input | 1 | Read without releasing (repeat-readout mode) |
| fill | output | $clog2(DEPTH)+1 | Number of words held |
| near_full | output | 1 | Fill has reached `NEAR_LEVEL` |

## Verification
The assertions assume two things about the inputs:

- `rd_keep` does not change while a packet is partly read.
- No packet is longer than `DEPTH` words while packet mode is on.

If either assumption is broken, the read position and fill accounting stop describing a real packet. The stimulus respects both. It holds `rd_keep` steady from the first word of a packet until its last word has been taken, and the longest packet it writes is exactly `DEPTH` words. Aborts arrive both with and without a write beat in the same cycle, and both while a packet is partly written and while none is.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

  function automatic bit is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/pfifo_store.sv
// Word storage: one synchronous write port, one asynchronous read port.
module pfifo_store #(
  parameter int WORD_W = 33,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wword;
  end

  assign rword = cells[raddr];
endmodule

// File: rtl/pfifo_wr_ctl.sv
// Write side: a speculative pointer plus a committed pointer that moves at packet end.
module pfifo_wr_ctl #(
  parameter int PTR_W    = 5,
  parameter bit ABORT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             push_last,
  input  logic             abort,
  output logic [PTR_W-1:0] spec_ptr,
  output logic [PTR_W-1:0] commit_ptr
);
  logic do_abort;
  assign do_abort = ABORT_EN && abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_ptr   <= '0;
      commit_ptr <= '0;
    end else if (do_abort) begin
      spec_ptr <= commit_ptr;
    end else if (push) begin
      spec_ptr <= spec_ptr + 1'b1;
      if (push_last) commit_ptr <= spec_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pfifo_rd_ctl.sv
// Read side: read pointer plus packet-start pointer that marks released space.
module pfifo_rd_ctl #(
  parameter int PTR_W     = 5,
  parameter bit REPEAT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             take_last,
  input  logic             keep,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] free_ptr
);
  generate
    if (REPEAT_EN) begin : g_repeat
      logic [PTR_W-1:0] start_ptr;
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_ptr    <= '0;
          start_ptr <= '0;
        end else if (take) begin
          if (keep) begin
            rd_ptr <= take_last ? start_ptr : rd_ptr + 1'b1;
          end else begin
            rd_ptr    <= rd_ptr + 1'b1;
            start_ptr <= rd_ptr + 1'b1;
          end
        end
      end
      assign free_ptr = start_ptr;
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)       rd_ptr <= '0;
        else if (take) rd_ptr <= rd_ptr + 1'b1;
      end
      assign free_ptr = rd_ptr;
    end
  endgenerate
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int NEAR_LEVEL = 12,
  parameter bit KEEP_LAST  = 1'b1,
  parameter bit PKT_MODE   = 1'b1,
  parameter bit ABORT_EN   = 1'b1,
  parameter bit REPEAT_EN  = 1'b1,
  parameter bit OUT_PIPE   = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_last,
  input  logic                     wr_abort,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_last,
  input  logic                     rd_keep,
  output logic [$clog2(DEPTH):0]   fill,
  output logic                     near_full
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int WORD_W = DATA_W + (KEEP_LAST ? 1 : 0);

  generate
    if (!pfifo_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("pkt_fifo: DEPTH must be a power of two");
    end
    if (REPEAT_EN && OUT_PIPE) begin : g_bad_mix
      $error("pkt_fifo: REPEAT_EN and OUT_PIPE exclude each other");
    end
    if ((PKT_MODE || REPEAT_EN) && !KEEP_LAST) begin : g_need_last
      $error("pkt_fifo: packet features need KEEP_LAST");
    end
    if ((ABORT_EN || REPEAT_EN) && !PKT_MODE) begin : g_need_pkt
      $error("pkt_fifo: abort and repeat need PKT_MODE");
    end
  endgenerate

  logic [PTR_W-1:0]  spec_ptr, commit_ptr, rd_ptr, free_ptr, avail_ptr, held;
  logic [WORD_W-1:0] in_word, mem_word, out_word;
  logic              push, mem_has, take, take_last, occ;

  assign push      = wr_valid && wr_ready;
  assign avail_ptr = PKT_MODE ? commit_ptr : spec_ptr;
  assign mem_has   = (rd_ptr != avail_ptr);
  assign held      = spec_ptr - free_ptr;

  generate
    if (KEEP_LAST) begin : g_last
      assign in_word   = {wr_last, wr_data};
      assign take_last = mem_word[WORD_W-1];
      assign rd_last   = out_word[WORD_W-1];
    end else begin : g_nolast
      assign in_word   = wr_data;
      assign take_last = 1'b0;
      assign rd_last   = 1'b0;
    end
  endgenerate
  assign rd_data = out_word[DATA_W-1:0];

  pfifo_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (spec_ptr[ADDR_W-1:0]),
    .wword (in_word),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rword (mem_word)
  );

  pfifo_wr_ctl #(.PTR_W(PTR_W), .ABORT_EN(ABORT_EN)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_last  (wr_last),
    .abort      (wr_abort),
    .spec_ptr   (spec_ptr),
    .commit_ptr (commit_ptr)
  );

  pfifo_rd_ctl #(.PTR_W(PTR_W), .REPEAT_EN(REPEAT_EN)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .take_last (take_last),
    .keep      (REPEAT_EN && rd_keep),
    .rd_ptr    (rd_ptr),
    .free_ptr  (free_ptr)
  );

  generate
    if (OUT_PIPE) begin : g_pipe
      logic              pipe_v;
      logic [WORD_W-1:0] pipe_w;
      assign take = mem_has && (!pipe_v || rd_ready);
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe_v <= 1'b0;
        end else if (take) begin
          pipe_v <= 1'b1;
        end else if (rd_ready) begin
          pipe_v <= 1'b0;
        end
        if (take) pipe_w <= mem_word;
      end
      assign rd_valid = pipe_v;
      assign out_word = pipe_w;
      assign occ      = pipe_v;
    end else begin : g_direct
      assign rd_valid = mem_has;
      assign out_word = mem_word;
      assign take     = mem_has && rd_ready;
      assign occ      = 1'b0;
    end
  endgenerate

  assign fill      = held + PTR_W'(occ);
  assign wr_ready  = (fill != PTR_W'(DEPTH));
  assign near_full = (fill >= PTR_W'(NEAR_LEVEL));
endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int NEAR_LEVEL = 12,
  parameter bit PKT_MODE   = 1'b1,
  parameter bit REPEAT_EN  = 1'b1,
  parameter bit OUT_PIPE   = 1'b0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic                   wr_last,
  input logic                   wr_abort,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   rd_keep,
  input logic [$clog2(DEPTH):0] fill,
  input logic                   near_full
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst || !live)
    fill <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst || !live)
    (wr_valid && !wr_ready && !rd_valid) |=> (fill == $past(fill)));

  assert_grow_needs_write_R4: assert property (@(posedge clk) disable iff (rst || !live)
    (fill > $past(fill)) |-> $past(wr_valid && wr_ready));

  assert_near_rise_R5: assert property (@(posedge clk) disable iff (rst || !live)
    $rose(near_full) |-> $past(wr_valid && wr_ready));

  assert_hold_data_R2: assert property (@(posedge clk) disable iff (rst || !live)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  generate
    if (PKT_MODE && !OUT_PIPE) begin : g_pkt
      assert_gate_R6: assert property (@(posedge clk) disable iff (rst || !live)
        $rose(rd_valid) |-> $past(wr_valid && wr_ready && wr_last));
    end
    if (REPEAT_EN) begin : g_rep
      assert_keep_no_free_R9: assert property (@(posedge clk) disable iff (rst || !live)
        (rd_valid && rd_ready && rd_keep && !wr_abort) |=> (fill >= $past(fill)));
    end
  endgenerate
endmodule

bind pkt_fifo pkt_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .NEAR_LEVEL(NEAR_LEVEL),
  .PKT_MODE(PKT_MODE), .REPEAT_EN(REPEAT_EN), .OUT_PIPE(OUT_PIPE)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_last(wr_last), .wr_abort(wr_abort), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .rd_keep(rd_keep),
  .fill(fill), .near_full(near_full)
);

// File: tb/sim_pkt_fifo.sv
module sim_pkt_fifo;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic wv0, wl0, dr0, rr0, pk0, wrdy0, rv0, rl0, af0;
  logic [7:0] wd0, rd0;
  logic [3:0] lvl0;
  logic wv1, wrdy1, rv1, rl1, af1;
  logic [7:0] wd1, rd1;
  logic [3:0] lvl1;

  pkt_fifo #(.DATA_W(8), .DEPTH(8), .NEAR_LEVEL(6)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wv0), .wr_ready(wrdy0), .wr_data(wd0),
    .wr_last(wl0), .wr_abort(dr0), .rd_valid(rv0), .rd_ready(rr0),
    .rd_data(rd0), .rd_last(rl0), .rd_keep(pk0), .fill(lvl0), .near_full(af0));

  pkt_fifo #(.DATA_W(8), .DEPTH(8), .NEAR_LEVEL(6), .PKT_MODE(1'b0),
             .ABORT_EN(1'b0), .REPEAT_EN(1'b0), .OUT_PIPE(1'b1)) u1 (
    .clk(clk), .rst(rst), .wr_valid(wv1), .wr_ready(wrdy1), .wr_data(wd1),
    .wr_last(1'b0), .wr_abort(1'b0), .rd_valid(rv1), .rd_ready(1'b0 | rr1),
    .rd_data(rd1), .rd_last(rl1), .rd_keep(1'b0), .fill(lvl1), .near_full(af1));
  logic rr1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Row: wv wl wd[8] abort rr keep | exp_valid exp_data[8] exp_last exp_fill[4]
  localparam int NROW = 12;
  localparam logic [26:0] ROWS [NROW] = '{
    {1'b1,1'b0,8'hA1,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,4'd1},
    {1'b1,1'b1,8'hA2,1'b0,1'b0,1'b0, 1'b1,8'hA1,1'b0,4'd2},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b1,8'hA2,1'b1,4'd2},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 1'b1,8'hA1,1'b0,4'd2},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0, 1'b1,8'hA2,1'b1,4'd1},
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b0, 1'b0,8'h00,1'b0,4'd0},
    {1'b1,1'b0,8'hB1,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,4'd1},
    {1'b1,1'b0,8'hB2,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,4'd0},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,4'd0},
    {1'b1,1'b1,8'hC1,1'b0,1'b0,1'b0, 1'b1,8'hC1,1'b1,4'd1},
    {1'b1,1'b0,8'hD1,1'b0,1'b1,1'b0, 1'b0,8'h00,1'b0,4'd1},
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b0,4'd0}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 1:       return "R6";
      2, 3:       return "R9";
      4, 5:       return "R10";
      6, 7, 11:   return "R7";
      8:          return "R8";
      default:    return "R4";
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1; wv0 = 0; wl0 = 0; wd0 = 0; dr0 = 0; rr0 = 0; pk0 = 0;
    wv1 = 0; wd1 = 0; rr1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: state after reset
    chk("R1 rd_valid", rv0, 0);
    chk("R1 fill", lvl0, 0);
    chk("R1 wr_ready", wrdy0, 1);
    chk("R1 near_full", af0, 0);

    for (int i = 0; i < NROW; i++) begin
      {wv0, wl0, wd0, dr0, rr0, pk0} = ROWS[i][26:14];
      tick();
      chk({row_req(i), " fill R4"}, lvl0, int'(ROWS[i][3:0]));
      chk({row_req(i), " rd_valid"}, rv0, int'(ROWS[i][13]));
      if (ROWS[i][13]) begin
        chk({row_req(i), " data R2"}, rd0, int'(ROWS[i][12:5]));
        chk({row_req(i), " last R2"}, rl0, int'(ROWS[i][4]));
      end
    end
    {wv0, wl0, wd0, dr0, rr0, pk0} = '0;

    // Fill to DEPTH with one packet: R3, R5, R6
    for (int i = 0; i < 8; i++) begin
      wv0 = 1; wd0 = 8'hE0 + 8'(i); wl0 = (i == 7);
      tick();
      chk("R4 fill while filling", lvl0, i + 1);
      chk("R5 near_full", af0, (i + 1) >= 6);
      if (i < 7) chk("R6 partial packet hidden", rv0, 0);
    end
    chk("R3 wr_ready at full", wrdy0, 0);
    wd0 = 8'hEE; wl0 = 0;
    tick();
    chk("R3 fill unchanged by blocked write", lvl0, 8);
    wv0 = 0;
    rr0 = 1;
    for (int i = 0; i < 8; i++) begin
      chk("R2 order data", rd0, 8'hE0 + i);
      chk("R2 last bit", rl0, i == 7);
      tick();
    end
    rr0 = 0;
    chk("R10 fill after release", lvl0, 0);
    chk("R10 rd_valid after release", rv0, 0);
    chk("R3 wr_ready after drain", wrdy0, 1);

    // Output register, non-packet configuration: R11
    wv1 = 1; wd1 = 8'h51;
    tick();
    chk("R11 not yet visible", rv1, 0);
    wd1 = 8'h52;
    tick();
    chk("R11 visible after two edges", rv1, 1);
    chk("R11 first data", rd1, 8'h51);
    chk("R11 fill counts output register", lvl1, 2);
    wd1 = 8'h53;
    tick();
    chk("R11 fill", lvl1, 3);
    chk("R2 held data", rd1, 8'h51);
    wv1 = 0; rr1 = 1;
    tick();
    chk("R11 second data", rd1, 8'h52);
    chk("R11 fill", lvl1, 2);
    tick();
    chk("R11 third data", rd1, 8'h53);
    chk("R11 fill", lvl1, 1);
    tick();
    chk("R11 empty", rv1, 0);
    chk("R11 fill zero", lvl1, 0);
    rr1 = 0;

    // Reset with committed data held: R1
    wv0 = 1; wl0 = 1; wd0 = 8'h77;
    tick();
    wv0 = 0; wl0 = 0;
    chk("R6 committed visible", rv0, 1);
    rst = 1;
    tick();
    rst = 0;
    chk("R1 fill after reset", lvl0, 0);
    chk("R1 rd_valid after reset", rv0, 0);
    chk("R1 near_full after reset", af0, 0);
    chk("R1 wr_ready after reset", wrdy0, 1);
    summary();
  end
endmodule